// File: doc/BRIEF.md
# Extended Sequencer Register File

This block holds the extended sequencer registers of a VGA-style display controller. Software reaches them through two ports. An index port selects a register and a data port writes the selected one, while the read data always shows the register at the current index. Some indices belong to the standard VGA sequencer, which sits outside this block. For those indices the block lowers its handled flag so that a neighbouring handler can serve the access.

Most extended indices are plain byte storage, but four kinds behave differently:

- **Unlock register.** A write to it stores one of two fixed codes.
- **Cursor X and cursor Y.** Each is reached through eight aliased indices. The three high index bits used on a write become the three low bits of an 11-bit position, and the data byte supplies the upper eight bits.
- **Configuration register.** Only part of it is writable. Each write to it produces a one-cycle strobe that tells the memory-access logic to reconfigure.
- **Unmapped indices.** These read as all ones and ignore writes.

Top module: `ext_seq_regfile`

## Requirements
- R1: After a synchronous active-low reset, every value is zero except two. The unlock register holds 0x0F and the configuration register holds the parameter `CFG_RESET` (default 0x28). This covers the index register, the cursor positions, the strobe and all storage.
- R2: When `index_we` is high at a clock edge, that edge loads `index_in` into the index register. A `data_we` at the same edge writes the register selected by the index held before that edge. `rd_data` and `handled` follow the index register combinationally.
- R3: For indices 0x00 to 0x04, `handled` is low and `rd_data` is 0x00. A data write at these indices changes no register of this block.
- R4: A data write at index 0x06 stores 0x12 when (data AND 0x17) equals 0x12, and stores 0x0F otherwise. Reading index 0x06 returns the stored code.
- R5: A data write at any index whose bits [4:0] equal 0x10 sets `cursor_x` to {data, index[7:5]}. Reading any of these eight indices returns `cursor_x[10:3]`.
- R6: A data write at any index whose bits [4:0] equal 0x11 sets `cursor_y` to {data, index[7:5]}. Reading any of these eight indices returns `cursor_y[10:3]`.
- R7: A data write at index 0x17 sets the configuration register to (old AND 0x38) OR (data AND 0xC7). Reading index 0x17 returns the configuration register.
- R8: `cfg_changed` is high for exactly the one cycle after each edge that performs a data write at index 0x17. It is low at all other times.
- R9: Indices 0x05, 0x07 to 0x0F, 0x12 to 0x16 and 0x18 to 0x1F each store a separate byte that reads back as last written.
- R10: An index of 0x20 or above whose bits [4:0] are neither 0x10 nor 0x11 reads as 0xFF with `handled` high. A data write there changes no register.
- R11: `handled` is high for every index of 0x05 or above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| index_we | input | 1 | Load `index_in` into the index register |
| index_in | input | 8 | New register index |
| data_we | input | 1 | Write `data_in` to the register at the current index |
| data_in | input | 8 | Write data |
| rd_data | output | 8 | Contents of the register at the current index |
| handled | output | 1 | Low when the current index belongs to the standard sequencer |
| cursor_x | output | 11 | Decoded cursor X position |
| cursor_y | output | 11 | Decoded cursor Y position |
| cfg_changed | output | 1 | One-cycle strobe after a configuration write |

## Verification
The hardest behaviour to expose from the ports is the configuration write that keeps three bits of the old value. A zero reset value would make those bits invisible, so the bench relies on the non-zero default of `CFG_RESET` and writes both all-ones and all-zeros data, expecting the kept bits to survive each write. The cursor aliasing is also difficult to observe, because the low position bits come from the index rather than the data. The bench walks all eight aliases of each axis and reads every value back through a different alias than the one written. It also issues an index load and a data write in the same cycle, to show that the write lands at the old index.

// File: rtl/ext_seq_pkg.sv
// Package: ext_seq_pkg
// Shared widths, index constants, the access-class type and the slot
// classifier for the extended sequencer register file.
// Assumes 8-bit indices and 8-bit data, the widths the index map is built on.
package ext_seq_pkg;

    localparam int ESR_DW = 8;
    localparam int ESR_IW = 8;
    localparam int ESR_ALIAS_BITS = 5;   // low index bits that select a cursor axis

    localparam logic [7:0] ESR_STD_LAST   = 8'h04;
    localparam logic [7:0] ESR_UNLOCK_IDX = 8'h06;
    localparam logic [7:0] ESR_CFG_IDX    = 8'h17;
    localparam logic [4:0] ESR_CURX_LO    = 5'h10;
    localparam logic [4:0] ESR_CURY_LO    = 5'h11;
    localparam logic [7:0] ESR_EXT_TOP    = 8'h1F;

    localparam logic [7:0] ESR_UNLOCK_MASK = 8'h17;
    localparam logic [7:0] ESR_UNLOCK_KEY  = 8'h12;
    localparam logic [7:0] ESR_LOCKED_CODE = 8'h0F;
    localparam logic [7:0] ESR_CFG_KEEP    = 8'h38;

    typedef enum logic [2:0] {
        CL_STD    = 3'd0,
        CL_UNLOCK = 3'd1,
        CL_CURX   = 3'd2,
        CL_CURY   = 3'd3,
        CL_CFG    = 3'd4,
        CL_PLAIN  = 3'd5,
        CL_NONE   = 3'd6
    } esr_class_e;

    // True when the slot number is an ordinary read/write byte.
    function automatic bit esr_is_plain(input int slot);
        return (slot == 5) ||
               ((slot >= 7) && (slot <= 31) &&
                (slot != 16) && (slot != 17) && (slot != 23));
    endfunction

endpackage

// File: rtl/esr_index_decode.sv
// Module: esr_index_decode
// Sorts the current register index into an access class.
// Purely combinational. Assumes the cursor aliases are recognised by the low
// five index bits, which take priority over the plain range.
module esr_index_decode
    import ext_seq_pkg::*;
#(
    parameter int IW = ESR_IW
) (
    input  logic [IW-1:0] idx,
    output esr_class_e    cls
);

    localparam int AB = ESR_ALIAS_BITS;

    // Classify the index; the order of the tests sets their priority.
    always_comb begin
        if (idx <= IW'(ESR_STD_LAST))
            cls = CL_STD;
        else if (idx == IW'(ESR_UNLOCK_IDX))
            cls = CL_UNLOCK;
        else if (idx[AB-1:0] == ESR_CURX_LO)
            cls = CL_CURX;
        else if (idx[AB-1:0] == ESR_CURY_LO)
            cls = CL_CURY;
        else if (idx == IW'(ESR_CFG_IDX))
            cls = CL_CFG;
        else if (idx <= IW'(ESR_EXT_TOP))
            cls = CL_PLAIN;
        else
            cls = CL_NONE;
    end

endmodule

// File: rtl/esr_plain_bank.sv
// Module: esr_plain_bank
// Byte storage for the ordinary extended registers.
// One register is built only for each slot that the package marks as plain;
// the other slots read as zero. The caller qualifies the write enable with
// the access class, so the slot number alone selects the target.
module esr_plain_bank
    import ext_seq_pkg::*;
#(
    parameter int DW    = ESR_DW,
    parameter int SLOTS = 32,
    localparam int SW   = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] slot,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] slot_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (esr_is_plain(g)) begin : g_reg
            // Hold one byte, loaded when this slot is written.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot_q[g] <= '0;
                else if (we && (slot == SW'(g)))
                    slot_q[g] <= wdata;
            end

            p_plain_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (we && (slot == SW'(g))) |=> (slot_q[g] == $past(wdata)));
            p_plain_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
                !(we && (slot == SW'(g))) |=> $stable(slot_q[g]));
        end else begin : g_gap
            assign slot_q[g] = '0;
        end
    end

    // Return the byte of the selected slot.
    always_comb rdata = slot_q[slot];

endmodule

// File: rtl/esr_cursor_axis.sv
// Module: esr_cursor_axis
// One cursor coordinate. On a write, the data byte becomes the high bits of
// the position and the high index bits of the alias used become the low bits.
// Assumes the caller has already decoded the alias for this axis.
module esr_cursor_axis #(
    parameter int DW = 8,
    parameter int HW = 3,
    localparam int PW = DW + HW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic [HW-1:0] idx_hi,
    output logic [PW-1:0] pos
);

    // Load the combined position on a write to any alias of this axis.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= '0;
        else if (we)
            pos <= {wdata, idx_hi};
    end

    p_cursor_low_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (pos[HW-1:0] == $past(idx_hi)));
    p_cursor_high_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (pos[PW-1:HW] == $past(wdata)));
    p_cursor_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(pos));

endmodule

// File: rtl/esr_ctrl_regs.sv
// Module: esr_ctrl_regs
// The unlock register, the partly writable configuration register and the
// reconfiguration strobe. Assumes the write enables arrive already decoded.
module esr_ctrl_regs
    import ext_seq_pkg::*;
#(
    parameter int          DW        = ESR_DW,
    parameter logic [DW-1:0] CFG_RESET = 8'h28
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          unlock_we,
    input  logic          cfg_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] unlock_q,
    output logic [DW-1:0] cfg_q,
    output logic          cfg_strobe
);

    localparam logic [DW-1:0] KEEP = DW'(ESR_CFG_KEEP);

    logic key_match;

    // Compare the masked write data with the unlock key.
    always_comb key_match = ((wdata & DW'(ESR_UNLOCK_MASK)) == DW'(ESR_UNLOCK_KEY));

    // Store one of the two unlock codes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            unlock_q <= DW'(ESR_LOCKED_CODE);
        else if (unlock_we)
            unlock_q <= key_match ? DW'(ESR_UNLOCK_KEY) : DW'(ESR_LOCKED_CODE);
    end

    // Merge writable bits of new data with the kept bits of the old value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= CFG_RESET;
        else if (cfg_we)
            cfg_q <= (cfg_q & KEEP) | (wdata & ~KEEP);
    end

    // Pulse for one cycle after each configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_strobe <= 1'b0;
        else
            cfg_strobe <= cfg_we;
    end

    p_unlock_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock_q == DW'(ESR_UNLOCK_KEY)) || (unlock_q == DW'(ESR_LOCKED_CODE)));
    p_cfg_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> ((cfg_q & KEEP) == ($past(cfg_q) & KEEP)));
    p_cfg_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> ((cfg_q & ~KEEP) == ($past(wdata) & ~KEEP)));
    p_cfg_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_strobe |-> $past(cfg_we));
    p_cfg_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q));

endmodule

// File: rtl/ext_seq_regfile.sv
// Module: ext_seq_regfile
// Indexed extended sequencer register file. It holds the index register,
// decodes the access class, routes data writes to the unlock, configuration,
// cursor and plain storage, and multiplexes the read data.
// Assumes the standard sequencer indices are served elsewhere when
// `handled` is low.
module ext_seq_regfile
    import ext_seq_pkg::*;
#(
    parameter int            DW        = ESR_DW,
    parameter int            IW        = ESR_IW,
    parameter logic [DW-1:0] CFG_RESET = 8'h28,
    localparam int           HW        = IW - ESR_ALIAS_BITS,
    localparam int           PW        = DW + HW,
    localparam int           SLOTS     = 1 << ESR_ALIAS_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          index_we,
    input  logic [IW-1:0] index_in,
    input  logic          data_we,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] rd_data,
    output logic          handled,
    output logic [PW-1:0] cursor_x,
    output logic [PW-1:0] cursor_y,
    output logic          cfg_changed
);

    logic [IW-1:0] idx_q;
    esr_class_e    cls;
    logic [DW-1:0] unlock_q;
    logic [DW-1:0] cfg_q;
    logic [DW-1:0] plain_rd;
    logic          plain_we;
    logic [PW-1:0] axis_pos [2];
    logic [1:0]    axis_we;

    // Hold the register index selected by software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (index_we)
            idx_q <= index_in;
    end

    esr_index_decode #(.IW(IW)) u_decode (
        .idx (idx_q),
        .cls (cls)
    );

    // Qualify the data write for each storage group.
    always_comb begin
        plain_we   = data_we && (cls == CL_PLAIN);
        axis_we[0] = data_we && (cls == CL_CURX);
        axis_we[1] = data_we && (cls == CL_CURY);
    end

    esr_ctrl_regs #(.DW(DW), .CFG_RESET(CFG_RESET)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .unlock_we  (data_we && (cls == CL_UNLOCK)),
        .cfg_we     (data_we && (cls == CL_CFG)),
        .wdata      (data_in),
        .unlock_q   (unlock_q),
        .cfg_q      (cfg_q),
        .cfg_strobe (cfg_changed)
    );

    esr_plain_bank #(.DW(DW), .SLOTS(SLOTS)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (plain_we),
        .slot  (idx_q[ESR_ALIAS_BITS-1:0]),
        .wdata (data_in),
        .rdata (plain_rd)
    );

    for (genvar a = 0; a < 2; a++) begin : g_axis
        esr_cursor_axis #(.DW(DW), .HW(HW)) u_axis (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (axis_we[a]),
            .wdata  (data_in),
            .idx_hi (idx_q[IW-1:ESR_ALIAS_BITS]),
            .pos    (axis_pos[a])
        );
    end

    assign cursor_x = axis_pos[0];
    assign cursor_y = axis_pos[1];

    // Select read data and the handled flag for the current index.
    always_comb begin
        handled = (cls != CL_STD);
        unique case (cls)
            CL_STD:    rd_data = '0;
            CL_UNLOCK: rd_data = unlock_q;
            CL_CURX:   rd_data = cursor_x[PW-1:HW];
            CL_CURY:   rd_data = cursor_y[PW-1:HW];
            CL_CFG:    rd_data = cfg_q;
            CL_PLAIN:  rd_data = plain_rd;
            default:   rd_data = '1;
        endcase
    end

    p_handled_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q > IW'(ESR_STD_LAST)) |-> handled);
    p_std_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q <= IW'(ESR_STD_LAST)) |-> (!handled && (rd_data == '0)));
    p_std_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !handled) |=> ($stable(cursor_x) && $stable(cursor_y) && !cfg_changed));
    p_index_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        index_we |=> (idx_q == $past(index_in)));
    p_unmapped_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CL_NONE) |-> (rd_data == '1));

endmodule

// File: tb/ext_seq_regfile_tb_top.sv
// Bench: ext_seq_regfile_tb_top
// Directed scenarios, one task each. Inputs change on the falling edge and
// outputs are sampled on the falling edge, away from the active edge.
module ext_seq_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        index_we = 1'b0;
    logic [7:0]  index_in = '0;
    logic        data_we = 1'b0;
    logic [7:0]  data_in = '0;
    logic [7:0]  rd_data;
    logic        handled;
    logic [10:0] cursor_x;
    logic [10:0] cursor_y;
    logic        cfg_changed;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ext_seq_regfile dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .index_we    (index_we),
        .index_in    (index_in),
        .data_we     (data_we),
        .data_in     (data_in),
        .rd_data     (rd_data),
        .handled     (handled),
        .cursor_x    (cursor_x),
        .cursor_y    (cursor_y),
        .cfg_changed (cfg_changed)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic set_index(input logic [7:0] i);
        @(negedge clk);
        index_we = 1'b1;
        index_in = i;
        @(negedge clk);
        index_we = 1'b0;
    endtask

    task automatic put_data(input logic [7:0] d);
        @(negedge clk);
        data_we = 1'b1;
        data_in = d;
        @(negedge clk);
        data_we = 1'b0;
    endtask

    task automatic write_reg(input logic [7:0] i, input logic [7:0] d);
        set_index(i);
        put_data(d);
    endtask

    task automatic expect_read(input string req, input logic [7:0] i, input logic [7:0] exp);
        set_index(i);
        check(req, {24'd0, rd_data}, {24'd0, exp});
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 index0 rd_data", {24'd0, rd_data}, 32'h0);
        check("R1 cursor_x", {21'd0, cursor_x}, 32'h0);
        check("R1 cursor_y", {21'd0, cursor_y}, 32'h0);
        check("R1 cfg_changed", {31'd0, cfg_changed}, 32'h0);
        expect_read("R1 unlock reset", 8'h06, 8'h0F);
        expect_read("R1 cfg reset", 8'h17, 8'h28);
        expect_read("R1 plain reset", 8'h05, 8'h00);
    endtask

    task automatic t_std();
        for (int i = 0; i <= 4; i++) begin
            write_reg(8'(i), 8'h55);
            check("R3 handled low", {31'd0, handled}, 32'h0);
            check("R3 rd_data zero", {24'd0, rd_data}, 32'h0);
            check("R3 no strobe", {31'd0, cfg_changed}, 32'h0);
        end
        check("R3 cursor_x untouched", {21'd0, cursor_x}, 32'h0);
        expect_read("R3 plain untouched", 8'h05, 8'h00);
        expect_read("R3 cfg untouched", 8'h17, 8'h28);
    endtask

    task automatic t_unlock();
        write_reg(8'h06, 8'h12);
        check("R4 key stores 0x12", {24'd0, rd_data}, 32'h12);
        write_reg(8'h06, 8'hFF);
        check("R4 other stores 0x0F", {24'd0, rd_data}, 32'h0F);
        write_reg(8'h06, 8'h3A);
        check("R4 masked key 0x3A", {24'd0, rd_data}, 32'h12);
        write_reg(8'h06, 8'h00);
        check("R4 zero stores 0x0F", {24'd0, rd_data}, 32'h0F);
    endtask

    task automatic t_cursor();
        for (int k = 0; k < 8; k++) begin
            logic [7:0] d;
            d = 8'hA0 + 8'(k * 3);
            write_reg(8'((k << 5) | 8'h10), d);
            check("R5 cursor_x value", {21'd0, cursor_x}, {21'd0, d, 3'(k)});
            expect_read("R5 alias read", 8'(((k + 3) % 8) << 5 | 8'h10), d);
        end
        for (int k = 0; k < 8; k++) begin
            logic [7:0] d;
            d = 8'h31 + 8'(k * 5);
            write_reg(8'((k << 5) | 8'h11), d);
            check("R6 cursor_y value", {21'd0, cursor_y}, {21'd0, d, 3'(k)});
            expect_read("R6 alias read", 8'(((k + 5) % 8) << 5 | 8'h11), d);
        end
        check("R5 cursor_x kept", {21'd0, cursor_x}, {21'd0, 8'hB5, 3'd7});
    endtask

    task automatic t_cfg();
        write_reg(8'h17, 8'hFF);
        check("R8 strobe high", {31'd0, cfg_changed}, 32'h1);
        check("R7 ones write", {24'd0, rd_data}, 32'hEF);
        @(negedge clk);
        check("R8 strobe one cycle", {31'd0, cfg_changed}, 32'h0);
        write_reg(8'h17, 8'h00);
        check("R8 strobe second write", {31'd0, cfg_changed}, 32'h1);
        check("R7 zeros write", {24'd0, rd_data}, 32'h28);
        write_reg(8'h17, 8'h81);
        check("R7 mixed write", {24'd0, rd_data}, 32'hA9);
        write_reg(8'h09, 8'h5A);
        check("R8 no strobe on plain", {31'd0, cfg_changed}, 32'h0);
    endtask

    task automatic t_plain();
        write_reg(8'h05, 8'h11);
        write_reg(8'h07, 8'h22);
        write_reg(8'h12, 8'h44);
        write_reg(8'h1F, 8'h33);
        write_reg(8'h18, 8'h66);
        expect_read("R9 slot 05", 8'h05, 8'h11);
        expect_read("R9 slot 07", 8'h07, 8'h22);
        expect_read("R9 slot 12", 8'h12, 8'h44);
        expect_read("R9 slot 1F", 8'h1F, 8'h33);
        expect_read("R9 slot 18", 8'h18, 8'h66);
        expect_read("R9 slot 09", 8'h09, 8'h5A);
    endtask

    task automatic t_unmapped();
        write_reg(8'h25, 8'h77);
        check("R10 reads ones", {24'd0, rd_data}, 32'hFF);
        check("R11 handled high", {31'd0, handled}, 32'h1);
        write_reg(8'hE5, 8'h12);
        check("R10 high index ones", {24'd0, rd_data}, 32'hFF);
        expect_read("R10 slot 05 untouched", 8'h05, 8'h11);
        expect_read("R10 unlock untouched", 8'h06, 8'h0F);
        set_index(8'h40);
        check("R10 index 40 ones", {24'd0, rd_data}, 32'hFF);
        check("R11 handled 40", {31'd0, handled}, 32'h1);
        set_index(8'h05);
        check("R11 handled 05", {31'd0, handled}, 32'h1);
    endtask

    task automatic t_index_timing();
        set_index(8'h0A);
        @(negedge clk);
        index_we = 1'b1;
        index_in = 8'h07;
        data_we  = 1'b1;
        data_in  = 8'h99;
        @(negedge clk);
        index_we = 1'b0;
        data_we  = 1'b0;
        check("R2 new index live", {24'd0, rd_data}, 32'h22);
        expect_read("R2 old index written", 8'h0A, 8'h99);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_std();
        t_unlock();
        t_cursor();
        t_cfg();
        t_plain();
        t_unmapped();
        t_index_timing();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

endmodule